// File: doc/BRIEF.md
# Miss-Merging Outstanding-Miss Table

This block sits between a cache's miss path and the memory request queue. It records every cache-line miss that is still waiting for data. When a second or later miss targets a line that already has a pending entry, the block reports it as merged and tells the caller not to send it downstream. Only the first miss to a line is forwarded. Each line entry keeps an ordered chain of the requester IDs waiting on that line. The chain has a bounded depth, and the number of line entries is a parameter.

When memory returns a line, the matching entry becomes the single active replay chain. The block hands its waiters out on a valid/ready replay port, one per accepted transfer, oldest first. Once the last waiter leaves, the entry is freed and can be reused.

There are three handshakes. The request port applies back-pressure through `req_ready`, and a request is taken only when `req_valid && req_ready`. The return port is not ready while a chain is being replayed, so one line drains fully before the next return is taken. The replay port keeps `rep_valid` and `rep_id` stable until `rep_ready` takes the waiter. A writeback return that matches no entry is discarded. Any other return that matches no entry raises an error pulse. Counters report total misses, merged misses, returns serviced and the peak number of waiter slots in use.

Top module: `mshr_merge_table`

## Requirements
- R1: A request's line is its byte address with the low log2(LINE_BYTES) bits cleared. With the default LINE_BYTES=64, addresses 0x1000, 0x1010 and 0x103C share one line, and 0x1040 is a different line.
- R2: An accepted request whose line has no pending entry shows `req_forward`=1 and `req_merged`=0 in its handshake cycle, and it takes a free entry.
- R3: An accepted request whose line has a pending entry shows `req_merged`=1 and `req_forward`=0, and its ID is appended to that line's chain.
- R4: An accepted return that matches a pending entry makes `rep_valid` high from the next cycle, with `rep_line` equal to the line's base address.
- R5: Waiters leave in insertion order, one per cycle with `rep_valid && rep_ready`. While `rep_ready` is low, `rep_valid` and `rep_id` hold.
- R6: The transfer of the last waiter drops `rep_valid` in the next cycle and frees the entry, so a later miss to any line can take that entry.
- R7: While a chain is being replayed, `ret_ready` is 0, and a request to the line being replayed sees `req_ready`=0.
- R8: An accepted return with `ret_wb`=1 that matches no entry starts no chain and raises no error. A return with `ret_wb`=0 that matches no entry makes `ret_err` high for exactly the next cycle.
- R9: `req_ready` is 0 when the request's line has a chain of CHAIN_DEPTH waiters. It is also 0 when the line has no entry and all N_LINES entries are busy.
- R10: `cnt_miss` counts accepted requests and `cnt_merge` counts accepted merged requests. `cnt_service` counts accepted returns that start a chain, and `peak_used` is the largest number of waiters held at once.
- R11: A synchronous active-high `rst` clears every entry, the active chain, the error flag and all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request offered |
| req_ready | output | 1 | Miss request can be taken |
| req_id | input | ID_W | Requester ID |
| req_addr | input | ADDR_W | Byte address of the miss |
| req_merged | output | 1 | Request joins a pending line (valid during handshake) |
| req_forward | output | 1 | Request must go to memory (valid during handshake) |
| ret_valid | input | 1 | Line return offered |
| ret_ready | output | 1 | Line return can be taken |
| ret_addr | input | ADDR_W | Address of the returning line |
| ret_wb | input | 1 | Return is a writeback completion |
| ret_err | output | 1 | Pulse: the previous return had no entry and was not a writeback |
| rep_valid | output | 1 | Replay waiter available |
| rep_ready | input | 1 | Consumer takes the replay waiter |
| rep_id | output | ID_W | Requester ID being replayed |
| rep_line | output | ADDR_W | Base address of the line being replayed |
| cnt_miss | output | CNT_W | Accepted requests |
| cnt_merge | output | CNT_W | Accepted merged requests |
| cnt_service | output | CNT_W | Returns that started a chain |
| peak_used | output | $clog2(N_LINES*CHAIN_DEPTH+1) | Peak waiters held |

## Verification
The request outputs `req_ready`, `req_merged` and `req_forward` are combinational, so the bench drives each request on a falling edge and checks them 1 ns later, before the rising edge that takes the request. After a return is accepted, the replay port, the error pulse and the counters each go through one register. They are therefore checked 1 ns after that rising edge. Each replay pop is checked on the falling edge before the edge that takes it. The end of the chain is checked one edge after the last pop. For every stalled case, ready is sampled low while valid is offered, and nothing has been taken.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  // How an accepted line return is disposed of.
  typedef enum logic [1:0] {
    RET_NONE  = 2'd0,
    RET_START = 2'd1,
    RET_DROP  = 2'd2,
    RET_ERR   = 2'd3
  } ret_kind_e;
endpackage

// File: rtl/mshr_chain.sv
module mshr_chain #(
  parameter int ID_W  = 6,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [ID_W-1:0]            push_id,
  input  logic                       pop,
  output logic [ID_W-1:0]            head_id,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [ID_W-1:0]  slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_q] <= push_id;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= nxt(wr_q);
      if (pop)  rd_q <= nxt(rd_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_id = slot_q[rd_q];
  assign count   = cnt_q;
  assign full    = (cnt_q == CW'(DEPTH));

  // R9
  chain_push_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt_q != CW'(DEPTH)));
  // R5
  chain_pop_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/mshr_stats.sv
module mshr_stats #(
  parameter int CNT_W  = 16,
  parameter int USED_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_req,
  input  logic              acc_merge,
  input  logic              chain_start,
  input  logic [USED_W-1:0] used_next,
  output logic [CNT_W-1:0]  cnt_miss,
  output logic [CNT_W-1:0]  cnt_merge,
  output logic [CNT_W-1:0]  cnt_service,
  output logic [USED_W-1:0] peak_used
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_miss    <= '0;
      cnt_merge   <= '0;
      cnt_service <= '0;
      peak_used   <= '0;
    end else begin
      if (acc_req)               cnt_miss    <= cnt_miss + CNT_W'(1);
      if (acc_req && acc_merge)  cnt_merge   <= cnt_merge + CNT_W'(1);
      if (chain_start)           cnt_service <= cnt_service + CNT_W'(1);
      if (used_next > peak_used) peak_used   <= used_next;
    end
  end

  // R10
  peak_mono_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (peak_used >= $past(peak_used)));
  // R10
  merge_le_miss_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_merge <= cnt_miss);
endmodule

// File: rtl/mshr_merge_table.sv
module mshr_merge_table
  import mshr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ID_W        = 6,
  parameter int LINE_BYTES  = 64,
  parameter int N_LINES     = 4,
  parameter int CHAIN_DEPTH = 4,
  parameter int CNT_W       = 16
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      req_valid,
  output logic                                      req_ready,
  input  logic [ID_W-1:0]                           req_id,
  input  logic [ADDR_W-1:0]                         req_addr,
  output logic                                      req_merged,
  output logic                                      req_forward,
  input  logic                                      ret_valid,
  output logic                                      ret_ready,
  input  logic [ADDR_W-1:0]                         ret_addr,
  input  logic                                      ret_wb,
  output logic                                      ret_err,
  output logic                                      rep_valid,
  input  logic                                      rep_ready,
  output logic [ID_W-1:0]                           rep_id,
  output logic [ADDR_W-1:0]                         rep_line,
  output logic [CNT_W-1:0]                          cnt_miss,
  output logic [CNT_W-1:0]                          cnt_merge,
  output logic [CNT_W-1:0]                          cnt_service,
  output logic [$clog2(N_LINES*CHAIN_DEPTH+1)-1:0]  peak_used
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1;
  localparam int CC_W   = $clog2(CHAIN_DEPTH + 1);
  localparam int SLOTS  = N_LINES * CHAIN_DEPTH;
  localparam int USED_W = $clog2(SLOTS + 1);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

  // per-entry state
  logic [ADDR_W-1:0] line_q  [N_LINES];
  logic [ID_W-1:0]   head_id [N_LINES];
  logic [CC_W-1:0]   ch_cnt  [N_LINES];
  logic [N_LINES-1:0] busy, full_v, push_v, pop_v;

  logic             act_q;
  logic [IDX_W-1:0] act_idx_q;
  logic [USED_W-1:0] used_q, used_next;
  logic             err_q;

  // lookup
  logic [ADDR_W-1:0]  req_line, ret_line;
  logic [N_LINES-1:0] req_hit_v, ret_hit_v;
  logic               req_hit, ret_hit, have_free;
  logic [IDX_W-1:0]   req_hit_idx, ret_hit_idx, free_idx;
  logic               req_hit_full, req_hit_act;
  logic               acc_req, acc_ret, pop, last_pop;
  ret_kind_e          ret_kind;

  assign req_line = req_addr & LINE_MASK;
  assign ret_line = ret_addr & LINE_MASK;

  always_comb begin
    req_hit_idx = '0;
    ret_hit_idx = '0;
    free_idx    = '0;
    have_free   = 1'b0;
    for (int i = 0; i < N_LINES; i++) begin
      req_hit_v[i] = busy[i] && (line_q[i] == req_line);
      ret_hit_v[i] = busy[i] && (line_q[i] == ret_line);
      if (req_hit_v[i]) req_hit_idx = IDX_W'(i);
      if (ret_hit_v[i]) ret_hit_idx = IDX_W'(i);
    end
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_idx  = IDX_W'(i);
        have_free = 1'b1;
      end
    end
  end

  assign req_hit      = |req_hit_v;
  assign ret_hit      = |ret_hit_v;
  assign req_hit_full = |(req_hit_v & full_v);
  assign req_hit_act  = act_q && req_hit_v[act_idx_q];

  // request side
  assign req_ready   = req_hit ? (!req_hit_full && !req_hit_act) : have_free;
  assign req_merged  = req_hit;
  assign req_forward = !req_hit;
  assign acc_req     = req_valid && req_ready;

  // return side
  assign ret_ready = !act_q;
  assign acc_ret   = ret_valid && ret_ready;

  always_comb begin
    if (!acc_ret)     ret_kind = RET_NONE;
    else if (ret_hit) ret_kind = RET_START;
    else if (ret_wb)  ret_kind = RET_DROP;
    else              ret_kind = RET_ERR;
  end

  // replay side
  assign rep_valid = act_q;
  assign rep_id    = head_id[act_idx_q];
  assign rep_line  = line_q[act_idx_q];
  assign pop       = act_q && rep_ready;
  assign last_pop  = pop && (ch_cnt[act_idx_q] == CC_W'(1));
  assign ret_err   = err_q;

  generate
    for (genvar g = 0; g < N_LINES; g++) begin : g_entry
      assign push_v[g] = acc_req && (req_hit ? req_hit_v[g] : (free_idx == IDX_W'(g)));
      assign pop_v[g]  = pop && (act_idx_q == IDX_W'(g));
      assign busy[g]   = (ch_cnt[g] != '0);

      mshr_chain #(.ID_W(ID_W), .DEPTH(CHAIN_DEPTH)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .push    (push_v[g]),
        .push_id (req_id),
        .pop     (pop_v[g]),
        .head_id (head_id[g]),
        .count   (ch_cnt[g]),
        .full    (full_v[g])
      );

      always_ff @(posedge clk) begin
        if (rst)                           line_q[g] <= '0;
        else if (push_v[g] && !req_hit)    line_q[g] <= req_line;
      end
    end
  endgenerate

  assign used_next = used_q + {{(USED_W-1){1'b0}}, acc_req} - {{(USED_W-1){1'b0}}, pop};

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      act_idx_q <= '0;
      used_q    <= '0;
      err_q     <= 1'b0;
    end else begin
      used_q <= used_next;
      err_q  <= (ret_kind == RET_ERR);
      if (ret_kind == RET_START) begin
        act_q     <= 1'b1;
        act_idx_q <= ret_hit_idx;
      end else if (last_pop) begin
        act_q <= 1'b0;
      end
    end
  end

  mshr_stats #(.CNT_W(CNT_W), .USED_W(USED_W)) u_stats (
    .clk         (clk),
    .rst         (rst),
    .acc_req     (acc_req),
    .acc_merge   (req_merged),
    .chain_start (ret_kind == RET_START),
    .used_next   (used_next),
    .cnt_miss    (cnt_miss),
    .cnt_merge   (cnt_merge),
    .cnt_service (cnt_service),
    .peak_used   (peak_used)
  );

  // R5
  rep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rep_valid && !rep_ready) |=> (rep_valid && $stable(rep_id) && $stable(rep_line)));
  // R7
  ret_block_chk: assert property (@(posedge clk) disable iff (rst)
    rep_valid |-> !ret_ready);
  // R8
  err_no_chain_chk: assert property (@(posedge clk) disable iff (rst)
    ret_err |-> !rep_valid);
  // R6
  used_bound_chk: assert property (@(posedge clk) disable iff (rst)
    used_q <= USED_W'(SLOTS));
  // R6
  chain_end_chk: assert property (@(posedge clk) disable iff (rst)
    last_pop |=> !rep_valid);
endmodule

// File: tb/mshr_merge_table_tb.sv
module mshr_merge_table_tb;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 6;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_ready, req_merged, req_forward;
  logic [ID_W-1:0]   req_id = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic ret_valid = 1'b0, ret_ready, ret_wb = 1'b0, ret_err;
  logic [ADDR_W-1:0] ret_addr = '0;
  logic rep_valid, rep_ready = 1'b0;
  logic [ID_W-1:0]   rep_id;
  logic [ADDR_W-1:0] rep_line;
  logic [CNT_W-1:0]  cnt_miss, cnt_merge, cnt_service;
  logic [4:0]        peak_used;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mshr_merge_table u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_addr(req_addr),
    .req_merged(req_merged), .req_forward(req_forward),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_addr(ret_addr), .ret_wb(ret_wb),
    .ret_err(ret_err),
    .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_id(rep_id), .rep_line(rep_line),
    .cnt_miss(cnt_miss), .cnt_merge(cnt_merge), .cnt_service(cnt_service),
    .peak_used(peak_used)
  );

  task automatic chk(input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic send_req(input int id, input logic [ADDR_W-1:0] a, input bit exp_merge,
                          input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_id = ID_W'(id); req_addr = a;
    #1;
    chk({tag, " req_ready"}, req_ready, 1);
    chk({tag, " req_merged"}, req_merged, exp_merge);
    chk({tag, " req_forward"}, req_forward, !exp_merge);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic probe_blocked(input logic [ADDR_W-1:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_id = '1; req_addr = a;
    #1;
    chk({tag, " req_ready low"}, req_ready, 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic send_ret(input logic [ADDR_W-1:0] a, input bit wb, input string tag);
    @(negedge clk);
    ret_valid = 1'b1; ret_addr = a; ret_wb = wb;
    #1;
    chk({tag, " ret_ready"}, ret_ready, 1);
    @(posedge clk); #1;
    ret_valid = 1'b0; ret_wb = 1'b0;
  endtask

  task automatic pop_expect(input int id, input logic [ADDR_W-1:0] line, input string tag);
    @(negedge clk);
    rep_ready = 1'b1;
    #1;
    chk({tag, " rep_valid"}, rep_valid, 1);
    chk({tag, " rep_id"}, rep_id, id);
    chk({tag, " rep_line"}, rep_line, line);
    @(posedge clk); #1;
    rep_ready = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R11 reset req_ready", req_ready, 1);
    chk("R11 reset ret_ready", ret_ready, 1);
    chk("R11 reset rep_valid", rep_valid, 0);
    chk("R11 reset ret_err", ret_err, 0);
    chk("R11 reset cnt_miss", cnt_miss, 0);
    chk("R11 reset peak_used", peak_used, 0);
  endtask

  task automatic t_merge;
    send_req(1, 32'h1000, 1'b0, "R2 first miss");
    send_req(2, 32'h1010, 1'b1, "R1 R3 same line");
    send_req(3, 32'h103C, 1'b1, "R1 R3 line top byte");
    send_req(4, 32'h2000, 1'b0, "R2 other line");
  endtask

  task automatic t_replay;
    send_ret(32'h1000, 1'b0, "R4 return");
    chk("R4 rep_valid after return", rep_valid, 1);
    chk("R7 ret_ready during replay", ret_ready, 0);
    probe_blocked(32'h1020, "R7 active line");
    repeat (2) begin
      @(negedge clk); #1;
      chk("R5 stalled rep_id", rep_id, 1);
      chk("R5 stalled rep_valid", rep_valid, 1);
    end
    pop_expect(1, 32'h1000, "R5 oldest");
    pop_expect(2, 32'h1000, "R5 second");
    pop_expect(3, 32'h1000, "R5 third");
    chk("R6 chain end rep_valid", rep_valid, 0);
    chk("R6 ret_ready restored", ret_ready, 1);
  endtask

  task automatic t_writeback;
    send_ret(32'h9000, 1'b1, "R8 wb orphan");
    chk("R8 wb no chain", rep_valid, 0);
    chk("R8 wb no err", ret_err, 0);
    send_ret(32'h9000, 1'b0, "R8 orphan");
    chk("R8 err pulse", ret_err, 1);
    chk("R8 no chain on err", rep_valid, 0);
    @(posedge clk); #1;
    chk("R8 err one cycle", ret_err, 0);
  endtask

  task automatic t_capacity;
    send_req(5, 32'h2004, 1'b1, "R3 fill");
    send_req(6, 32'h2008, 1'b1, "R3 fill");
    send_req(7, 32'h200C, 1'b1, "R3 fill");
    probe_blocked(32'h2010, "R9 chain full");
    send_req(8, 32'h3000, 1'b0, "R2 entry");
    send_req(9, 32'h4000, 1'b0, "R2 entry");
    send_req(10, 32'h5000, 1'b0, "R2 entry");
    probe_blocked(32'h6000, "R9 entries full");
    send_req(11, 32'h3004, 1'b1, "R9 merge still ok");
  endtask

  task automatic t_drain_reuse;
    send_ret(32'h2000, 1'b0, "R4 return 2");
    pop_expect(4, 32'h2000, "R5 chain2 a");
    pop_expect(5, 32'h2000, "R5 chain2 b");
    pop_expect(6, 32'h2000, "R5 chain2 c");
    pop_expect(7, 32'h2000, "R5 chain2 d");
    chk("R6 chain2 end", rep_valid, 0);
    send_req(12, 32'h6000, 1'b0, "R6 reuse freed entry");
  endtask

  task automatic t_counters;
    chk("R10 cnt_miss", cnt_miss, 12);
    chk("R10 cnt_merge", cnt_merge, 6);
    chk("R10 cnt_service", cnt_service, 2);
    chk("R10 peak_used", peak_used, 8);
  endtask

  task automatic t_mid_reset;
    send_ret(32'h3000, 1'b0, "R11 pre-reset return");
    chk("R11 chain live", rep_valid, 1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R11 rep_valid cleared", rep_valid, 0);
    chk("R11 ret_ready", ret_ready, 1);
    chk("R11 cnt_miss cleared", cnt_miss, 0);
    chk("R11 cnt_service cleared", cnt_service, 0);
    chk("R11 peak cleared", peak_used, 0);
    send_req(13, 32'h3000, 1'b0, "R11 entries cleared");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_merge();
    t_replay();
    t_writeback();
    t_capacity();
    t_drain_reuse();
    t_counters();
    t_mid_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule